// File: doc/BRIEF.md
# Cuckoo-Hashed Miss Status Buffer

This block keeps track of the cache lines that a non-blocking cache has requested from external memory and is still waiting for. Each tracked line occupies one entry that records the line address and a pointer to the first row of the line's subentry list, which the subentry logic manages. When the cache misses, it presents the line address together with a freshly allocated row pointer. The block answers in the same cycle. On a primary miss it creates an entry, returns the new pointer and issues one memory fetch. On a secondary miss it returns the pointer already stored and issues no fetch.

Entries live in three hash tables that are probed in parallel, one index per table. A small stash also holds entries, and every lookup searches it alongside the tables. If all three candidate slots of a new line are occupied, the new line takes the slot in the first table and the previous occupant moves to the stash. In cycles with no accepted request and no response, the stash entry with the lowest slot number is reinserted. It goes into a free candidate slot if one exists. Otherwise it evicts the occupant of one table, and that occupant takes its place in the stash. Each stash entry may perform only a bounded number of such evictions. When a memory response returns, the block looks up its line address, hands back the stored pointer and frees the entry.

Top module: `mshr_cuckoo`

## Requirements
- R1: After reset nothing is tracked. `stash_full` is low, `req_ready` is high while no response is presented, and a response finds no entry.
- R2: An accepted request for an untracked line is a primary miss. In the same cycle `req_hit` is 0, `req_ptr` equals `req_new_ptr`, `mem_req_valid` is 1 and `mem_req_line` equals `req_line`.
- R3: An accepted request for a tracked line is a secondary miss. In the same cycle `req_hit` is 1, `req_ptr` is the pointer stored when the line was first tracked, and `mem_req_valid` is 0. A line is held in at most one place.
- R4: The index of a line in table t is the XOR of the 3-bit groups of (line XOR salt_t), where each table has a different salt. Lines whose 3-bit groups XOR to the same value therefore compete for the same three slots. Three such lines fit in the tables, and any further ones are held in the stash.
- R5: A response for a tracked line raises `rsp_found` in the same cycle and returns the stored pointer on `rsp_ptr`. From the next cycle on, the line is untracked, so a new request for it is a primary miss.
- R6: While `rsp_valid` is high, `req_ready` is low and a presented request is neither taken nor fetched.
- R7: `stash_full` rises only in the cycle after a primary miss, once all four stash slots hold entries. While it is high, `req_ready` is low. It falls within two idle cycles after a response frees an entry.
- R8: A response for an untracked line leaves `rsp_found` low and changes no tracked entry.
- R9: Lines held in the stash are found by requests (as secondary misses) and by responses.
- R10: Background reinsertion never loses or duplicates a line. After any number of idle cycles, every tracked line still returns its own pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A missing line is presented |
| req_line | input | 12 | Line address of the miss |
| req_new_ptr | input | 6 | Row pointer to store if the miss is primary |
| req_ready | output | 1 | The presented request is taken this cycle |
| req_hit | output | 1 | The line was already tracked (secondary miss) |
| req_ptr | output | 6 | Row pointer for the line |
| mem_req_valid | output | 1 | Fetch the line from memory |
| mem_req_line | output | 12 | Line address to fetch |
| rsp_valid | input | 1 | A memory response is returning |
| rsp_line | input | 12 | Line address of the response |
| rsp_found | output | 1 | The response matched a tracked entry |
| rsp_ptr | output | 6 | Stored row pointer of that entry |
| stash_full | output | 1 | Every stash slot is occupied |

## Verification
The request and response results (`req_hit`, `req_ptr`, `mem_req_valid`, `rsp_found`, `rsp_ptr`) come from combinational logic in the cycle in which the inputs are presented. The bench therefore drives inputs after a falling edge and samples 1 ns later, before the rising edge that commits any write. An insertion or deallocation becomes visible from the next cycle. Stash reinsertion needs idle cycles, so the bench waits one idle cycle after each table vector and two after a response before it checks `stash_full` again. Every later lookup is compared against a reference map kept in the bench, whichever table or stash slot holds the line at that moment.

// File: rtl/mshr_cuckoo_pkg.sv
package mshr_cuckoo_pkg;
  parameter int unsigned LINE_W   = 12;
  parameter int unsigned IDX_W    = 3;
  parameter int unsigned PTR_W    = 6;
  parameter int unsigned N_TBL    = 3;
  parameter int unsigned STASH_N  = 4;
  parameter int unsigned MAX_KICK = 4;

  localparam int unsigned KICK_W  = $clog2(MAX_KICK + 1);
  localparam int unsigned TSEL_W  = (N_TBL > 1) ? $clog2(N_TBL) : 1;
  localparam int unsigned SIDX_W  = (STASH_N > 1) ? $clog2(STASH_N) : 1;
  localparam int unsigned CHUNKS  = (LINE_W + IDX_W - 1) / IDX_W;

  typedef struct packed {
    logic              vld;
    logic [LINE_W-1:0] line;
    logic [PTR_W-1:0]  ptr;
  } ent_t;

  // per-table salt taken from a fixed odd constant
  function automatic logic [LINE_W-1:0] tbl_salt(input int unsigned t);
    logic [63:0] k;
    k = 64'h9E37_79B9_7F4A_7C15 >> (t * 11);
    return k[LINE_W-1:0];
  endfunction

  // XOR-fold of salted line address into IDX_W bits
  function automatic logic [IDX_W-1:0] tbl_hash(input logic [LINE_W-1:0] line,
                                                input int unsigned t);
    logic [LINE_W-1:0] x;
    logic [IDX_W-1:0]  h;
    x = line ^ tbl_salt(t);
    h = '0;
    for (int c = 0; c < CHUNKS; c++) h ^= IDX_W'(x >> (c * IDX_W));
    return h;
  endfunction
endpackage

// File: rtl/mct_way.sv
module mct_way
  import mshr_cuckoo_pkg::*;
#(
  parameter int unsigned TBL_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] probe_line,
  output ent_t              slot,
  input  logic              wr_en,
  input  ent_t              wr_ent
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  ent_t             mem_q [DEPTH];
  logic [IDX_W-1:0] idx;

  assign idx  = tbl_hash(probe_line, TBL_ID);
  assign slot = mem_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[idx] <= wr_ent;
    end
  end
endmodule

// File: rtl/mct_stash.sv
module mct_stash
  import mshr_cuckoo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] probe_line,
  output logic              hit,
  output logic [PTR_W-1:0]  hit_ptr,
  input  logic              clr_en,
  input  logic              push_en,
  input  ent_t              push_ent,
  input  logic              pop_en,
  input  logic              repl_en,
  input  ent_t              repl_ent,
  output logic              head_vld,
  output ent_t              head_ent,
  output logic [KICK_W-1:0] head_kicks,
  output logic              full
);
  ent_t              slot_q [STASH_N];
  logic [KICK_W-1:0] kick_q [STASH_N];
  logic [SIDX_W-1:0] hit_sel, head_sel, free_sel;
  logic              any_free;

  always_comb begin
    hit = 1'b0; hit_sel = '0; hit_ptr = '0;
    head_vld = 1'b0; head_sel = '0;
    any_free = 1'b0; free_sel = '0;
    for (int i = 0; i < STASH_N; i++) begin
      if (slot_q[i].vld && slot_q[i].line == probe_line) begin
        hit = 1'b1; hit_sel = SIDX_W'(i); hit_ptr = slot_q[i].ptr;
      end
      if (slot_q[i].vld && !head_vld) begin
        head_vld = 1'b1; head_sel = SIDX_W'(i);
      end
      if (!slot_q[i].vld && !any_free) begin
        any_free = 1'b1; free_sel = SIDX_W'(i);
      end
    end
  end

  assign full       = !any_free;
  assign head_ent   = slot_q[head_sel];
  assign head_kicks = kick_q[head_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STASH_N; i++) begin
        slot_q[i] <= '0;
        kick_q[i] <= '0;
      end
    end else if (clr_en) begin
      slot_q[hit_sel] <= '0;
    end else if (push_en && any_free) begin
      slot_q[free_sel] <= push_ent;
      kick_q[free_sel] <= '0;
    end else if (pop_en) begin
      slot_q[head_sel] <= '0;
    end else if (repl_en) begin
      slot_q[head_sel] <= repl_ent;
      kick_q[head_sel] <= head_kicks + KICK_W'(1);
    end
  end
endmodule

// File: rtl/mshr_cuckoo.sv
module mshr_cuckoo
  import mshr_cuckoo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic [PTR_W-1:0]  req_new_ptr,
  output logic              req_ready,
  output logic              req_hit,
  output logic [PTR_W-1:0]  req_ptr,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_line,
  input  logic              rsp_valid,
  input  logic [LINE_W-1:0] rsp_line,
  output logic              rsp_found,
  output logic [PTR_W-1:0]  rsp_ptr,
  output logic              stash_full
);
  // named internal events, watched by the checker
  logic              probe_rsp, probe_req, probe_drn;
  logic [LINE_W-1:0] probe_line;
  logic [N_TBL-1:0]  tbl_match;
  logic [N_TBL:0]    match_vec;
  logic              any_hit;
  logic [PTR_W-1:0]  hit_ptr;

  ent_t              slot_w [N_TBL];
  logic [N_TBL-1:0]  wr_en;
  ent_t              wr_ent;

  logic              st_hit, st_clr, st_push, st_pop, st_repl;
  logic [PTR_W-1:0]  st_hit_ptr;
  ent_t              push_ent, repl_ent, head_ent;
  logic              head_vld;
  logic [KICK_W-1:0] head_kicks;

  logic              free_any;
  logic [TSEL_W-1:0] free_sel, victim;

  // one probe per cycle: response first, then request, then stash drain
  assign probe_rsp  = rsp_valid;
  assign probe_req  = !rsp_valid && req_valid && !stash_full;
  assign probe_drn  = !rsp_valid && !probe_req && head_vld;
  assign probe_line = probe_rsp ? rsp_line : (probe_req ? req_line : head_ent.line);

  for (genvar t = 0; t < N_TBL; t++) begin : g_way
    mct_way #(.TBL_ID(t)) u_way (
      .clk        (clk),
      .rst_n      (rst_n),
      .probe_line (probe_line),
      .slot       (slot_w[t]),
      .wr_en      (wr_en[t]),
      .wr_ent     (wr_ent)
    );
  end

  mct_stash u_stash (
    .clk        (clk),
    .rst_n      (rst_n),
    .probe_line (probe_line),
    .hit        (st_hit),
    .hit_ptr    (st_hit_ptr),
    .clr_en     (st_clr),
    .push_en    (st_push),
    .push_ent   (push_ent),
    .pop_en     (st_pop),
    .repl_en    (st_repl),
    .repl_ent   (repl_ent),
    .head_vld   (head_vld),
    .head_ent   (head_ent),
    .head_kicks (head_kicks),
    .full       (stash_full)
  );

  always_comb begin
    tbl_match = '0;
    free_any  = 1'b0;
    free_sel  = '0;
    hit_ptr   = st_hit_ptr;
    for (int t = 0; t < N_TBL; t++) begin
      tbl_match[t] = slot_w[t].vld && (slot_w[t].line == probe_line);
      if (tbl_match[t]) hit_ptr = slot_w[t].ptr;
      if (!slot_w[t].vld && !free_any) begin
        free_any = 1'b1;
        free_sel = TSEL_W'(t);
      end
    end
  end

  assign match_vec = {st_hit, tbl_match};
  assign any_hit   = |match_vec;
  assign victim    = TSEL_W'(head_kicks % KICK_W'(N_TBL));

  always_comb begin
    wr_en    = '0;
    wr_ent   = '0;
    st_clr   = 1'b0;
    st_push  = 1'b0;
    push_ent = slot_w[0];
    st_pop   = 1'b0;
    st_repl  = 1'b0;
    repl_ent = '0;
    if (probe_rsp) begin
      wr_en  = tbl_match;
      st_clr = st_hit;
    end else if (probe_req && !any_hit) begin
      wr_ent = '{vld: 1'b1, line: req_line, ptr: req_new_ptr};
      if (free_any) begin
        wr_en[free_sel] = 1'b1;
      end else begin
        wr_en[0] = 1'b1;
        st_push  = 1'b1;
      end
    end else if (probe_drn) begin
      wr_ent = head_ent;
      if (free_any) begin
        wr_en[free_sel] = 1'b1;
        st_pop          = 1'b1;
      end else if (head_kicks < KICK_W'(MAX_KICK)) begin
        wr_en[victim] = 1'b1;
        st_repl       = 1'b1;
        repl_ent      = slot_w[victim];
      end
    end
  end

  assign req_ready     = !rsp_valid && !stash_full;
  assign req_hit       = probe_req && any_hit;
  assign req_ptr       = any_hit ? hit_ptr : req_new_ptr;
  assign mem_req_valid = probe_req && !any_hit;
  assign mem_req_line  = req_line;
  assign rsp_found     = probe_rsp && any_hit;
  assign rsp_ptr       = hit_ptr;
endmodule

// File: rtl/mshr_cuckoo_chk.sv
module mshr_cuckoo_chk
  import mshr_cuckoo_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_hit,
  input logic           mem_req_valid,
  input logic           rsp_valid,
  input logic           stash_full,
  input logic [N_TBL:0] match_vec
);
  assert_fetch_only_primary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (req_valid && req_ready && !req_hit));

  assert_single_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match_vec) <= 1);

  assert_rsp_blocks_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_full_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stash_full |-> !req_ready);

  assert_fill_after_primary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stash_full) |-> $past(mem_req_valid));
endmodule

bind mshr_cuckoo mshr_cuckoo_chk u_chk (.*);

// File: tb/mshr_cuckoo_tb.sv
module mshr_cuckoo_tb;
  import mshr_cuckoo_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [LINE_W-1:0] req_line = '0;
  logic [PTR_W-1:0]  req_new_ptr = '0;
  logic              req_ready, req_hit, mem_req_valid, rsp_found, stash_full;
  logic [PTR_W-1:0]  req_ptr, rsp_ptr;
  logic [LINE_W-1:0] mem_req_line;
  logic              rsp_valid = 1'b0;
  logic [LINE_W-1:0] rsp_line = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [PTR_W-1:0] ref_m [int];

  always #5 clk = ~clk;

  mshr_cuckoo u_dut (.*);

  typedef struct packed {
    logic              is_rsp;
    logic [LINE_W-1:0] line;
    logic [PTR_W-1:0]  ptr;
    logic              exp_hit;
    logic [PTR_W-1:0]  exp_ptr;
  } vec_t;

  // lines 0000,0011,0022,0033 (octal) share one slot set (R4)
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'o0000, 6'd1, 1'b0, 6'd1},
    '{1'b0, 12'o0011, 6'd2, 1'b0, 6'd2},
    '{1'b0, 12'o0022, 6'd3, 1'b0, 6'd3},
    '{1'b0, 12'o0033, 6'd4, 1'b0, 6'd4},
    '{1'b0, 12'o0000, 6'd9, 1'b1, 6'd1},
    '{1'b0, 12'o0033, 6'd9, 1'b1, 6'd4},
    '{1'b0, 12'o0007, 6'd5, 1'b0, 6'd5},
    '{1'b1, 12'o0011, 6'd0, 1'b1, 6'd2},
    '{1'b0, 12'o0011, 6'd6, 1'b0, 6'd6},
    '{1'b1, 12'o0777, 6'd0, 1'b0, 6'd0},
    '{1'b0, 12'o0007, 6'd9, 1'b1, 6'd5},
    '{1'b1, 12'o0033, 6'd0, 1'b1, 6'd4}
  };

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [LINE_W-1:0] line, input logic [PTR_W-1:0] p,
                        input logic exp_hit, input logic [PTR_W-1:0] exp_ptr,
                        input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_line = line; req_new_ptr = p;
    #1;
    check(req_ready === 1'b1, rq, "req_ready", int'(req_ready), 1);
    check(req_hit === exp_hit, rq, "req_hit", int'(req_hit), int'(exp_hit));
    check(req_ptr === exp_ptr, rq, "req_ptr", int'(req_ptr), int'(exp_ptr));
    check(mem_req_valid === !exp_hit, rq, "mem_req_valid", int'(mem_req_valid), int'(!exp_hit));
    if (!exp_hit) begin
      check(mem_req_line === line, rq, "mem_req_line", int'(mem_req_line), int'(line));
      ref_m[int'(line)] = p;
    end
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic do_rsp(input logic [LINE_W-1:0] line, input logic exp_found,
                        input logic [PTR_W-1:0] exp_ptr, input string rq);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_line = line;
    #1;
    check(rsp_found === exp_found, rq, "rsp_found", int'(rsp_found), int'(exp_found));
    if (exp_found) begin
      check(rsp_ptr === exp_ptr, rq, "rsp_ptr", int'(rsp_ptr), int'(exp_ptr));
      ref_m.delete(int'(line));
    end
    @(posedge clk); #1 rsp_valid = 1'b0;
  endtask

  task automatic req_ref(input logic [LINE_W-1:0] line, input logic [PTR_W-1:0] p,
                         input string rq);
    logic h;
    h = ref_m.exists(int'(line));
    do_req(line, p, h, h ? ref_m[int'(line)] : p, rq);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; rsp_valid = 1'b0;
    ref_m.delete();
    idle(2);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    @(negedge clk); #1;
    check(stash_full === 1'b0, "R1", "stash_full", int'(stash_full), 0);
    check(req_ready === 1'b1, "R1", "req_ready", int'(req_ready), 1);
    check(mem_req_valid === 1'b0, "R1", "mem_req_valid", int'(mem_req_valid), 0);
    do_rsp(12'o0123, 1'b0, '0, "R1");

    // vector walk: R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rsp) do_rsp(VEC[i].line, VEC[i].exp_hit, VEC[i].exp_ptr, "R5_R8_R9");
      else do_req(VEC[i].line, VEC[i].ptr, VEC[i].exp_hit, VEC[i].exp_ptr, "R2_R3_R4_R9");
      idle(1);
    end
    req_ref(12'o0033, 6'd7, "R5");   // freed line is primary again

    // R6: response and request together
    @(negedge clk);
    rsp_valid = 1'b1; rsp_line = 12'o0777;
    req_valid = 1'b1; req_line = 12'o0543; req_new_ptr = 6'd20;
    #1;
    check(req_ready === 1'b0, "R6", "req_ready", int'(req_ready), 0);
    check(mem_req_valid === 1'b0, "R6", "mem_req_valid", int'(mem_req_valid), 0);
    @(posedge clk); #1 rsp_valid = 1'b0; req_valid = 1'b0;
    req_ref(12'o0543, 6'd21, "R6");

    // R7: fill the stash with lines of the shared slot set
    do_rsp(12'o0033, 1'b1, 6'd7, "R7");
    idle(3);
    req_ref(12'o0044, 6'd30, "R7");
    req_ref(12'o0055, 6'd31, "R7");
    req_ref(12'o0066, 6'd32, "R7");
    req_ref(12'o0101, 6'd33, "R7");
    idle(4);
    @(negedge clk);
    req_valid = 1'b1; req_line = 12'o0110; req_new_ptr = 6'd34;
    #1;
    check(stash_full === 1'b1, "R7", "stash_full", int'(stash_full), 1);
    check(req_ready === 1'b0, "R7", "req_ready", int'(req_ready), 0);
    check(mem_req_valid === 1'b0, "R7", "mem_req_valid", int'(mem_req_valid), 0);
    @(posedge clk); #1 req_valid = 1'b0;
    do_rsp(12'o0044, 1'b1, 6'd30, "R7_R9");
    idle(2);
    @(negedge clk); #1;
    check(stash_full === 1'b0, "R7", "stash_full", int'(stash_full), 0);
    check(req_ready === 1'b1, "R7", "req_ready", int'(req_ready), 1);

    // R10: after many idle cycles every tracked line keeps its pointer
    idle(20);
    foreach (ref_m[k]) req_ref(LINE_W'(k), 6'd63, "R10");

    // mixed traffic against the reference map
    do_reset();
    begin
      logic [15:0] lf;
      logic [PTR_W-1:0] pc;
      lf = 16'hACE1; pc = '0;
      for (int i = 0; i < 300; i++) begin
        logic [LINE_W-1:0] ln;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        ln = LINE_W'((int'(lf[3:0]) * 423 + 53) & 12'hFFF);
        if (ref_m.exists(int'(ln)) && (lf[5] || ref_m.num() >= 8))
          do_rsp(ln, 1'b1, ref_m[int'(ln)], "R5_R9");
        else if (ref_m.num() < 8) begin
          pc = pc + 1'b1;
          req_ref(ln, pc, "R2_R3_R10");
        end
        if (lf[7]) idle(1);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule